// File: doc/BRIEF.md
# Paged MDIO Register Access Bridge

This block is a management-bus master. It turns 32-bit register operations into sequences of 16-bit MDIO frame transactions for a device whose register space sits behind a page register. The supported operations are read, write, half-word read and write, masked read-modify-write, and poll-until-match. A client presents one request at a time on a valid/ready port. The request carries a byte address, write data, a clear mask, set bits, an expected value and a retry count. The bridge answers with a one-cycle done pulse, the read data and an error flag.

On the downstream side the bridge drives a frame engine through a request/acknowledge port. That port carries a 5-bit PHY address, a 5-bit register number, 16-bit write data and a write flag. The serial bit timing belongs to that engine and is outside this block.

The bridge caches the last page it wrote. It writes the page register only when a request needs a different page, and it then waits a settling interval before touching data registers. Polls are spaced by a programmable idle interval.

Top module: `mdio_page_bridge`

## Requirements
- R1: The byte address is split into page = addr[17:9], sub-PHY = addr[8:6] and register = addr[5:1]. Every data transaction targets PHY address 5'b10 followed by the 3-bit sub-PHY.
- R2: When the page cache is empty (always true after reset) or holds a different page, the first transaction is a write of the 9-bit page, zero-extended, to PHY 0x18 register 0.
- R3: After a page write, no further transaction starts until at least SETTLE_CYC idle cycles have passed.
- R4: When the requested page equals the cached page, neither a page write nor a settling wait occurs.
- R5: A 32-bit read (op 0) reads register N and then register N+1, and returns {second, first}.
- R6: A 32-bit write (op 1) writes data[15:0] to register N and data[31:16] to N+1. With cfg_lo_first = 1 the low half goes first; with cfg_lo_first = 0 the high half goes first.
- R7: Half accesses issue exactly one transaction. Low-half read (op 2) and low-half write (op 4) use the address as given. High-half read (op 3) and high-half write (op 5) use address+2. A low read returns {16'h0, value}, a high read returns {value, 16'h0}, and a high write sends data[31:16].
- R8: Modify (op 6) reads the word, computes (word & ~mask) | set, writes it back in the half order of R6, and returns the word it read.
- R9: Wait (op 7) reads the word and compares (word & mask) with the expected value. A match finishes with the error flag clear. A mismatch while the retry count is zero finishes with the error flag set. Otherwise the bridge decrements the count, idles at least POLL_CYC cycles and polls again, so at most count+1 polls are made.
- R10: After reset, req_ready = 1, done = 0 and mdio_req = 0. A request is accepted when req_valid and req_ready are both high. req_ready then stays low until done, a single-cycle pulse that coincides with req_ready returning high.
- R11: An error reported on any transaction is ORed into rsp_err. All remaining transactions of the sequence are still issued.
- R12: mdio_req and its address, data and direction fields stay constant from the cycle mdio_req rises until the cycle mdio_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle, request accepted this cycle if valid |
| req_op | input | 3 | Operation code (see R5 to R9) |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 32 | Write data |
| req_mask | input | 32 | Clear mask (modify) or compare mask (wait) |
| req_set | input | 32 | Bits ORed in by modify |
| req_expect | input | 32 | Value expected by wait |
| req_timeout | input | TMO_W | Retry count for wait |
| cfg_lo_first | input | 1 | Low half written first when set |
| done | output | 1 | Result valid pulse |
| rsp_data | output | 32 | Read result |
| rsp_err | output | 1 | Error or wait timeout |
| mdio_req | output | 1 | Transaction request to frame engine |
| mdio_phy | output | 5 | PHY address |
| mdio_reg | output | 5 | Register number |
| mdio_wdata | output | 16 | Write data |
| mdio_write | output | 1 | 1 = write, 0 = read |
| mdio_ack | input | 1 | Transaction complete |
| mdio_rdata | input | 16 | Read data, valid with ack |
| mdio_err | input | 1 | Transaction error, valid with ack |

## Verification
Two decisions can land on the same cycle: the final acknowledge of a sequence, and an error carried by that same acknowledge. For a wait, the same final acknowledge also decides both the compare and the exhaustion of the retry count. The bench injects an engine error on the last transaction of a read and checks that the data is intact and the flag is set. It also runs a wait whose count reaches zero on a mismatching poll, and checks that exactly count+1 polls were issued before the flag rose. The idle gap after a page write and between polls is measured from transaction timestamps taken in the responder.

// File: rtl/mpb_pkg.sv
`timescale 1ns/1ps
package mpb_pkg;
  localparam int PAGE_LSB = 9;
  localparam int PAGE_W   = 9;
  localparam int PHY_LSB  = 6;
  localparam int PHY_W    = 3;
  localparam int REG_LSB  = 1;
  localparam int REG_W    = 5;
  localparam int ADDR_W   = PAGE_LSB + PAGE_W;
  localparam int HALF_W   = 16;
  localparam int WORD_W   = 2 * HALF_W;
  localparam int MPHY_W   = 5;

  localparam logic [MPHY_W-1:0] PAGE_PHY = 5'h18;
  localparam logic [REG_W-1:0]  PAGE_REG = '0;
  localparam logic [1:0]        DATA_PHY_HI = 2'b10;

  typedef enum logic [2:0] {
    OP_READ     = 3'd0,
    OP_WRITE    = 3'd1,
    OP_READ_LO  = 3'd2,
    OP_READ_HI  = 3'd3,
    OP_WRITE_LO = 3'd4,
    OP_WRITE_HI = 3'd5,
    OP_MODIFY   = 3'd6,
    OP_WAIT     = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PAGE, S_SETTLE, S_XFER, S_GAP
  } state_e;

  typedef struct packed {
    logic wr;     // transaction is a write
    logic upper;  // targets register N+1
    logic last;   // final transaction of the sequence
  } step_t;

  function automatic logic is_hi_half(op_e op);
    return (op == OP_READ_HI) || (op == OP_WRITE_HI);
  endfunction

  // Which transaction a given step of an operation issues.
  function automatic step_t step_plan(op_e op, logic [1:0] s, logic lo_first);
    step_t p;
    logic  wr_upper;
    wr_upper = lo_first ? s[0] : ~s[0];
    p = '0;
    unique case (op)
      OP_READ, OP_WAIT: begin
        p.wr = 1'b0; p.upper = s[0]; p.last = (s == 2'd1);
      end
      OP_WRITE: begin
        p.wr = 1'b1; p.upper = wr_upper; p.last = (s == 2'd1);
      end
      OP_MODIFY: begin
        p.wr    = s[1];
        p.upper = s[1] ? wr_upper : s[0];
        p.last  = (s == 2'd3);
      end
      OP_WRITE_LO, OP_WRITE_HI: begin
        p.wr = 1'b1; p.upper = 1'b0; p.last = 1'b1;
      end
      default: begin
        p.wr = 1'b0; p.upper = 1'b0; p.last = 1'b1;
      end
    endcase
    return p;
  endfunction

  function automatic logic [WORD_W-1:0] merge_bits(logic [WORD_W-1:0] word,
                                                   logic [WORD_W-1:0] clr,
                                                   logic [WORD_W-1:0] set);
    return (word & ~clr) | set;
  endfunction

  function automatic logic poll_match(logic [WORD_W-1:0] word,
                                      logic [WORD_W-1:0] msk,
                                      logic [WORD_W-1:0] expv);
    return (word & msk) == expv;
  endfunction

  function automatic logic [WORD_W-1:0] finish_word(op_e op,
                                                    logic [HALF_W-1:0] last_rd,
                                                    logic [HALF_W-1:0] lo,
                                                    logic [HALF_W-1:0] hi);
    unique case (op)
      OP_READ, OP_WAIT: return {last_rd, lo};
      OP_MODIFY:        return {hi, lo};
      OP_READ_LO:       return {{HALF_W{1'b0}}, last_rd};
      OP_READ_HI:       return {last_rd, {HALF_W{1'b0}}};
      default:          return '0;
    endcase
  endfunction
endpackage

// File: rtl/mpb_addr_split.sv
`timescale 1ns/1ps
module mpb_addr_split
  import mpb_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              hi_half,
  output logic [PAGE_W-1:0] page,
  output logic [PHY_W-1:0]  sub_phy,
  output logic [REG_W-1:0]  reg_num
);
  localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(2);

  logic [ADDR_W-1:0] eff;
  logic              unused_lsb;

  assign eff        = hi_half ? (addr + HALF_STEP) : addr;
  assign page       = eff[PAGE_LSB +: PAGE_W];
  assign sub_phy    = eff[PHY_LSB +: PHY_W];
  assign reg_num    = eff[REG_LSB +: REG_W];
  assign unused_lsb = eff[0];
endmodule

// File: rtl/mpb_page_cache.sv
`timescale 1ns/1ps
module mpb_page_cache
  import mpb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [PAGE_W-1:0] upd_page,
  input  logic [PAGE_W-1:0] query,
  output logic              hit
);
  logic              valid_q;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      page_q  <= '0;
    end else if (upd) begin
      valid_q <= 1'b1;
      page_q  <= upd_page;
    end
  end

  assign hit = valid_q && (page_q == query);
endmodule

// File: rtl/mpb_interval_timer.sv
`timescale 1ns/1ps
module mpb_interval_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic             fire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start)        cnt_q <= load;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign fire = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/mdio_page_bridge.sv
`timescale 1ns/1ps
module mdio_page_bridge
  import mpb_pkg::*;
#(
  parameter int SETTLE_CYC = 100000,
  parameter int POLL_CYC   = 50,
  parameter int TMO_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [17:0]       req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [31:0]       req_mask,
  input  logic [31:0]       req_set,
  input  logic [31:0]       req_expect,
  input  logic [TMO_W-1:0]  req_timeout,
  input  logic              cfg_lo_first,
  output logic              done,
  output logic [31:0]       rsp_data,
  output logic              rsp_err,
  output logic              mdio_req,
  output logic [4:0]        mdio_phy,
  output logic [4:0]        mdio_reg,
  output logic [15:0]       mdio_wdata,
  output logic              mdio_write,
  input  logic              mdio_ack,
  input  logic [15:0]       mdio_rdata,
  input  logic              mdio_err
);
  localparam int MAX_CYC = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  state_e              state_q;
  op_e                 op_q;
  op_e                 in_op;
  logic [PHY_W-1:0]    phy_q;
  logic [REG_W-1:0]    reg_q;
  logic [PAGE_W-1:0]   page_q;
  logic [WORD_W-1:0]   wval_q, mask_q, set_q, exp_q, rsp_data_q;
  logic [HALF_W-1:0]   rd_lo_q, rd_hi_q;
  logic [1:0]          step_q;
  logic [TMO_W-1:0]    tmo_q;
  logic                lo_first_q, err_acc_q, done_q, rsp_err_q;

  logic [PAGE_W-1:0]   sp_page;
  logic [PHY_W-1:0]    sp_phy;
  logic [REG_W-1:0]    sp_reg;
  logic                page_hit;
  step_t               cur;

  // Named internal events
  logic                accept, page_ack, xfer_ack, settle_done, gap_done;
  logic                seq_finish, poll_retry, poll_hit, err_now, tmr_fire;
  logic [WORD_W-1:0]   rd_word;
  logic [CNT_W-1:0]    tmr_load;

  assign in_op = op_e'(req_op);

  mpb_addr_split u_split (
    .addr    (req_addr),
    .hi_half (is_hi_half(in_op)),
    .page    (sp_page),
    .sub_phy (sp_phy),
    .reg_num (sp_reg)
  );

  mpb_page_cache u_cache (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (settle_done),
    .upd_page (page_q),
    .query    (sp_page),
    .hit      (page_hit)
  );

  assign tmr_load = page_ack ? CNT_W'(SETTLE_CYC) : CNT_W'(POLL_CYC);

  mpb_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (page_ack | poll_retry),
    .load  (tmr_load),
    .fire  (tmr_fire)
  );

  assign cur         = step_plan(op_q, step_q, lo_first_q);
  assign accept      = req_valid && (state_q == S_IDLE);
  assign page_ack    = (state_q == S_PAGE) && mdio_ack;
  assign xfer_ack    = (state_q == S_XFER) && mdio_ack;
  assign settle_done = (state_q == S_SETTLE) && tmr_fire;
  assign gap_done    = (state_q == S_GAP) && tmr_fire;
  assign rd_word     = {mdio_rdata, rd_lo_q};
  assign err_now     = err_acc_q | mdio_err;
  assign poll_hit    = poll_match(rd_word, mask_q, exp_q);
  assign poll_retry  = xfer_ack && cur.last && (op_q == OP_WAIT) && !poll_hit
                       && (tmo_q != '0);
  assign seq_finish  = xfer_ack && cur.last && !poll_retry;

  // Downstream transaction fields
  assign mdio_req   = (state_q == S_PAGE) || (state_q == S_XFER);
  assign mdio_phy   = (state_q == S_PAGE) ? PAGE_PHY : {DATA_PHY_HI, phy_q};
  assign mdio_reg   = (state_q == S_PAGE) ? PAGE_REG : (reg_q + REG_W'(cur.upper));
  assign mdio_write = (state_q == S_PAGE) || cur.wr;
  always_comb begin
    if (state_q == S_PAGE)
      mdio_wdata = HALF_W'(page_q);
    else if (cur.upper || (op_q == OP_WRITE_HI))
      mdio_wdata = wval_q[WORD_W-1:HALF_W];
    else
      mdio_wdata = wval_q[HALF_W-1:0];
  end

  assign req_ready = (state_q == S_IDLE);
  assign done      = done_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_err   = rsp_err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      op_q       <= OP_READ;
      phy_q      <= '0;
      reg_q      <= '0;
      page_q     <= '0;
      wval_q     <= '0;
      mask_q     <= '0;
      set_q      <= '0;
      exp_q      <= '0;
      tmo_q      <= '0;
      lo_first_q <= 1'b0;
      rd_lo_q    <= '0;
      rd_hi_q    <= '0;
      step_q     <= '0;
      err_acc_q  <= 1'b0;
      done_q     <= 1'b0;
      rsp_data_q <= '0;
      rsp_err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (accept) begin
            op_q       <= in_op;
            page_q     <= sp_page;
            phy_q      <= sp_phy;
            reg_q      <= sp_reg;
            wval_q     <= req_wdata;
            mask_q     <= req_mask;
            set_q      <= req_set;
            exp_q      <= req_expect;
            tmo_q      <= req_timeout;
            lo_first_q <= cfg_lo_first;
            step_q     <= '0;
            err_acc_q  <= 1'b0;
            state_q    <= page_hit ? S_XFER : S_PAGE;
          end
        end
        S_PAGE: begin
          if (page_ack) begin
            err_acc_q <= err_now;
            state_q   <= S_SETTLE;
          end
        end
        S_SETTLE: begin
          if (settle_done) state_q <= S_XFER;
        end
        S_XFER: begin
          if (xfer_ack) begin
            err_acc_q <= err_now;
            if (!cur.wr) begin
              if (cur.upper) rd_hi_q <= mdio_rdata;
              else           rd_lo_q <= mdio_rdata;
            end
            if ((op_q == OP_MODIFY) && (step_q == 2'd1))
              wval_q <= merge_bits(rd_word, mask_q, set_q);
            if (seq_finish) begin
              done_q     <= 1'b1;
              rsp_data_q <= finish_word(op_q, mdio_rdata, rd_lo_q, rd_hi_q);
              rsp_err_q  <= ((op_q == OP_WAIT) && !poll_hit) ? 1'b1 : err_now;
              state_q    <= S_IDLE;
            end else if (poll_retry) begin
              tmo_q   <= tmo_q - 1'b1;
              step_q  <= '0;
              state_q <= S_GAP;
            end else begin
              step_q <= step_q + 1'b1;
            end
          end
        end
        S_GAP: begin
          if (gap_done) state_q <= S_XFER;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mpb_checker.sv
`timescale 1ns/1ps
module mpb_checker #(
  parameter int SETTLE_CYC = 100000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        done,
  input logic        mdio_req,
  input logic        mdio_ack,
  input logic [4:0]  mdio_phy,
  input logic [4:0]  mdio_reg,
  input logic [15:0] mdio_wdata,
  input logic        mdio_write,
  input logic        seq_finish
);
  logic        after_pg_q;
  logic [31:0] idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      after_pg_q <= 1'b0;
      idle_q     <= '0;
    end else if (mdio_req && mdio_ack && (mdio_phy == 5'h18)) begin
      after_pg_q <= 1'b1;
      idle_q     <= '0;
    end else if (mdio_req) begin
      after_pg_q <= 1'b0;
    end else if (after_pg_q) begin
      idle_q <= idle_q + 1;
    end
  end

  AST_PAGE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && mdio_phy == 5'h18) |-> (mdio_write && mdio_reg == 5'd0)); // R2
  AST_DATA_PHY: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && mdio_phy != 5'h18) |-> (mdio_phy[4:3] == 2'b10)); // R1
  AST_SETTLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (after_pg_q && mdio_req) |-> (idle_q >= SETTLE_CYC)); // R3
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && !mdio_ack) |=> (mdio_req && $stable(mdio_phy) && $stable(mdio_reg)
                                  && $stable(mdio_write) && $stable(mdio_wdata))); // R12
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R10
  AST_IDLE_NO_MDIO: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mdio_req); // R10
  AST_FINISH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_finish |=> (done && req_ready)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
endmodule

bind mdio_page_bridge mpb_checker #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .done       (done),
  .mdio_req   (mdio_req),
  .mdio_ack   (mdio_ack),
  .mdio_phy   (mdio_phy),
  .mdio_reg   (mdio_reg),
  .mdio_wdata (mdio_wdata),
  .mdio_write (mdio_write),
  .seq_finish (seq_finish)
);

// File: tb/mdio_page_bridge_test.sv
`timescale 1ns/1ps
module mdio_page_bridge_test;
  localparam int SETTLE = 20;
  localparam int POLL   = 8;
  localparam int TW     = 8;
  localparam int LAT    = 2;
  localparam logic [17:0] A1 = 18'h00748; // page 3, sub-PHY 5, reg 4
  localparam logic [17:0] A2 = 18'h34A94; // page 0x1A5, sub-PHY 2, reg 10

  typedef struct packed {
    logic [2:0]  op;
    logic [17:0] addr;
    logic [31:0] wdata, mask, setb, expv;
    logic [7:0]  tmo;
    logic        lof;
    logic [31:0] rdata;
    logic        err;
    logic [7:0]  ntx;
  } vec_t;

  localparam vec_t VECS [0:13] = '{
    '{3'd1, A1, 32'h12345678, 32'h0, 32'h0, 32'h0, 8'd0, 1'b1, 32'h0,        1'b0, 8'd3},
    '{3'd0, A1, 32'h0, 32'h0, 32'h0, 32'h0, 8'd0, 1'b1, 32'h12345678,        1'b0, 8'd2},
    '{3'd1, A2, 32'hDEADBEEF, 32'h0, 32'h0, 32'h0, 8'd0, 1'b0, 32'h0,        1'b0, 8'd3},
    '{3'd0, A2, 32'h0, 32'h0, 32'h0, 32'h0, 8'd0, 1'b1, 32'hDEADBEEF,        1'b0, 8'd2},
    '{3'd0, A1, 32'h0, 32'h0, 32'h0, 32'h0, 8'd0, 1'b1, 32'h12345678,        1'b0, 8'd3},
    '{3'd4, A1, 32'h0000AAAA, 32'h0, 32'h0, 32'h0, 8'd0, 1'b1, 32'h0,        1'b0, 8'd1},
    '{3'd0, A1, 32'h0, 32'h0, 32'h0, 32'h0, 8'd0, 1'b1, 32'h1234AAAA,        1'b0, 8'd2},
    '{3'd5, A1, 32'h55550000, 32'h0, 32'h0, 32'h0, 8'd0, 1'b1, 32'h0,        1'b0, 8'd1},
    '{3'd3, A1, 32'h0, 32'h0, 32'h0, 32'h0, 8'd0, 1'b1, 32'h55550000,        1'b0, 8'd1},
    '{3'd2, A1, 32'h0, 32'h0, 32'h0, 32'h0, 8'd0, 1'b1, 32'h0000AAAA,        1'b0, 8'd1},
    '{3'd6, A1, 32'h0, 32'h0000FF00, 32'h00000300, 32'h0, 8'd0, 1'b1, 32'h5555AAAA, 1'b0, 8'd4},
    '{3'd0, A1, 32'h0, 32'h0, 32'h0, 32'h0, 8'd0, 1'b1, 32'h555503AA,        1'b0, 8'd2},
    '{3'd7, A1, 32'h0, 32'h0000FFFF, 32'h0, 32'h000003AA, 8'd3, 1'b1, 32'h555503AA, 1'b0, 8'd2},
    '{3'd7, A1, 32'h0, 32'hFFFFFFFF, 32'h0, 32'h0, 8'd2, 1'b1, 32'h555503AA, 1'b1, 8'd6}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, cfg_lo_first = 1'b1;
  logic        req_ready, done, rsp_err;
  logic [2:0]  req_op = '0;
  logic [17:0] req_addr = '0;
  logic [31:0] req_wdata = '0, req_mask = '0, req_set = '0, req_expect = '0, rsp_data;
  logic [TW-1:0] req_timeout = '0;
  logic        mdio_req, mdio_write, mdio_ack, mdio_err;
  logic [4:0]  mdio_phy, mdio_reg;
  logic [15:0] mdio_wdata, mdio_rdata;

  int checks = 0, errors = 0;
  int leak = 0, dbl = 0, stable_viol = 0, cyc = 0;
  int log_n = 0, inj_idx = -1;
  logic [4:0]  lg_phy [0:15];
  logic [4:0]  lg_reg [0:15];
  logic        lg_wr  [0:15];
  logic [15:0] lg_data[0:15];
  int          lg_t0  [0:15];
  int          lg_t1  [0:15];
  logic [15:0] store [int];
  logic [8:0]  dev_page = '0;
  logic [31:0] got_data;
  logic        got_err;

  always #10 clk = ~clk;

  mdio_page_bridge #(.SETTLE_CYC(SETTLE), .POLL_CYC(POLL), .TMO_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .req_set(req_set), .req_expect(req_expect), .req_timeout(req_timeout),
    .cfg_lo_first(cfg_lo_first), .done(done), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .mdio_req(mdio_req), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
    .mdio_wdata(mdio_wdata), .mdio_write(mdio_write), .mdio_ack(mdio_ack),
    .mdio_rdata(mdio_rdata), .mdio_err(mdio_err)
  );

  // Register-file responder standing in for the frame engine and device
  initial begin : responder
    int wcnt; int key; int t0;
    logic [4:0] c_phy, c_reg; logic [15:0] c_wd; logic c_wr;
    wcnt = 0; t0 = 0;
    c_phy = '0; c_reg = '0; c_wd = '0; c_wr = 1'b0;
    mdio_ack = 1'b0; mdio_err = 1'b0; mdio_rdata = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (mdio_ack) begin
        mdio_ack = 1'b0; mdio_err = 1'b0;
      end else if (mdio_req) begin
        if (wcnt == 0) begin
          t0 = cyc; c_phy = mdio_phy; c_reg = mdio_reg; c_wd = mdio_wdata; c_wr = mdio_write;
        end else if (c_phy != mdio_phy || c_reg != mdio_reg || c_wd != mdio_wdata
                     || c_wr != mdio_write) begin
          stable_viol++;
        end
        wcnt++;
        if (wcnt == LAT) begin
          wcnt = 0;
          key = int'({dev_page, c_phy[2:0], c_reg});
          if (c_phy == 5'h18 && c_reg == 5'd0 && c_wr) dev_page = c_wd[8:0];
          else if (c_wr) store[key] = c_wd;
          else mdio_rdata = store.exists(key) ? store[key] : 16'(key * 7 + 16'h5A3C);
          if (log_n < 16) begin
            lg_phy[log_n] = c_phy; lg_reg[log_n] = c_reg; lg_wr[log_n] = c_wr;
            lg_data[log_n] = c_wr ? c_wd : mdio_rdata;
            lg_t0[log_n] = t0; lg_t1[log_n] = cyc;
          end
          mdio_err = (log_n == inj_idx);
          log_n++;
          mdio_ack = 1'b1;
        end
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] expv);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, expv);
    end
  endtask

  task automatic run_op(input vec_t v);
    int n;
    @(negedge clk);
    req_op = v.op; req_addr = v.addr; req_wdata = v.wdata; req_mask = v.mask;
    req_set = v.setb; req_expect = v.expv; req_timeout = v.tmo; cfg_lo_first = v.lof;
    log_n = 0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 5000) begin
      if (req_ready) leak++;
      @(negedge clk);
      n++;
    end
    got_data = rsp_data; got_err = rsp_err;
    @(negedge clk);
    if (done) dbl++;
  endtask

  function automatic vec_t mk(input logic [2:0] op, input logic [17:0] a,
                              input logic [31:0] wd, input logic [31:0] m,
                              input logic [31:0] s, input logic [31:0] e,
                              input logic [7:0] t, input logic lof);
    vec_t v;
    v = '0;
    v.op = op; v.addr = a; v.wdata = wd; v.mask = m; v.setb = s; v.expv = e;
    v.tmo = t; v.lof = lof;
    return v;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 ready after reset", 32'(req_ready), 32'd1);
    chk("R10 done after reset", 32'(done), 32'd0);
    chk("R10 mdio_req after reset", 32'(mdio_req), 32'd0);
    rst_n = 1'b1;

    // Table: R2 R4 R5 R6 R7 R8 R9 via data, error and transaction counts
    for (int i = 0; i < 14; i++) begin
      run_op(VECS[i]);
      chk($sformatf("R5/R6/R7/R8/R9 vec %0d data", i), got_data, VECS[i].rdata);
      chk($sformatf("R9 vec %0d err", i), 32'(got_err), 32'(VECS[i].err));
      chk($sformatf("R2/R4 vec %0d transactions", i), 32'(log_n), 32'(VECS[i].ntx));
    end

    // R1 R5 R4: read order on a cached page
    run_op(mk(3'd0, A1, 0, 0, 0, 0, 0, 1'b1));
    chk("R4 no page write on hit", 32'(log_n), 32'd2);
    chk("R1 data PHY address", 32'(lg_phy[0]), 32'h15);
    chk("R5 first read reg N", 32'(lg_reg[0]), 32'd4);
    chk("R5 second read reg N+1", 32'(lg_reg[1]), 32'd5);

    // R6 write order both ways
    run_op(mk(3'd1, A1, 32'hCAFEF00D, 0, 0, 0, 0, 1'b0));
    chk("R6 hi-first reg", 32'(lg_reg[0]), 32'd5);
    chk("R6 hi-first data", 32'(lg_data[0]), 32'hCAFE);
    chk("R6 hi-first then lo", 32'(lg_data[1]), 32'hF00D);
    run_op(mk(3'd1, A1, 32'h0BADBEEF, 0, 0, 0, 0, 1'b1));
    chk("R6 lo-first reg", 32'(lg_reg[0]), 32'd4);
    chk("R6 lo-first data", 32'(lg_data[0]), 32'hBEEF);

    // R2 R3: page change
    run_op(mk(3'd0, A2, 0, 0, 0, 0, 0, 1'b1));
    chk("R2 page write PHY", 32'(lg_phy[0]), 32'h18);
    chk("R2 page write reg", 32'(lg_reg[0]), 32'd0);
    chk("R2 page write data", 32'(lg_data[0]), 32'h1A5);
    chk("R3 settle gap exceeded", 32'((lg_t0[1] - lg_t1[0]) > SETTLE), 32'd1);
    chk("R2 read after page", got_data, 32'hDEADBEEF);

    // R11: error on the final acknowledge
    inj_idx = 1;
    run_op(mk(3'd0, A2, 0, 0, 0, 0, 0, 1'b1));
    inj_idx = -1;
    chk("R11 err flag", 32'(got_err), 32'd1);
    chk("R11 data intact", got_data, 32'hDEADBEEF);
    // R11: error on first of a write, second still issued
    inj_idx = 0;
    run_op(mk(3'd1, A2, 32'hDEADBEEF, 0, 0, 0, 0, 1'b1));
    inj_idx = -1;
    chk("R11 write err flag", 32'(got_err), 32'd1);
    chk("R11 remaining step issued", 32'(log_n), 32'd2);

    // R9: poll spacing and count+1 polls
    run_op(mk(3'd7, A2, 0, 32'hFFFFFFFF, 0, 0, 8'd1, 1'b1));
    chk("R9 timeout err", 32'(got_err), 32'd1);
    chk("R9 two polls", 32'(log_n), 32'd4);
    chk("R9 poll gap exceeded", 32'((lg_t0[2] - lg_t1[1]) > POLL), 32'd1);

    // R8: modify with high half written first
    run_op(mk(3'd6, A2, 0, 32'hFFFF0000, 32'h12340000, 0, 0, 1'b0));
    chk("R8 returns old word", got_data, 32'hDEADBEEF);
    chk("R8 upper written first", 32'(lg_reg[2]), 32'd11);
    chk("R8 merged upper", 32'(lg_data[2]), 32'h1234);
    chk("R8 merged lower", 32'(lg_data[3]), 32'hBEEF);

    // R7: high-half write lands at N+1
    run_op(mk(3'd5, A2, 32'hA5A50000, 0, 0, 0, 0, 1'b1));
    chk("R7 one transaction", 32'(log_n), 32'd1);
    chk("R7 high half reg", 32'(lg_reg[0]), 32'd11);
    chk("R7 high half data", 32'(lg_data[0]), 32'hA5A5);

    // R10 R2: reset empties the page cache
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R10 ready in reset", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    run_op(mk(3'd0, A2, 0, 0, 0, 0, 0, 1'b1));
    chk("R2 page rewritten after reset", 32'(log_n), 32'd3);
    chk("R2 data after reset", got_data, 32'hA5A5BEEF);

    chk("R10 ready low while busy", 32'(leak), 32'd0);
    chk("R10 done single pulse", 32'(dbl), 32'd0);
    chk("R12 fields held until ack", 32'(stable_viol), 32'd0);

    summary();
    $finish;
  end
endmodule